// File: doc/BRIEF.md
# Partial-Word Merge Unit

This block performs left and right partial-word loads and stores on 32-bit words. A request carries a byte address, an operation code, an endianness flag and a register value. For a load, the unit reads the aligned memory word and combines the selected byte lanes of that word with the register value. The merged register value appears on `result`. For a store, the unit reads the aligned word, merges the selected register lanes into it, and writes the merged word back to the same aligned address. The written word also appears on `result`.

The unit talks to a simple word memory through a single request channel. `mem_req`, `mem_we` and `mem_addr` form one beat. The memory accepts that beat by raising `mem_ready`. On a read beat, the memory returns `mem_rdata` in the same cycle as `mem_ready`.

A four-state machine sequences the work:
- IDLE: the unit accepts a request (IDLE→READ on `req_valid`).
- READ: the unit issues the aligned read. On `mem_ready`, READ→IDLE for a load, or READ→MERGE for a store.
- MERGE: the unit registers the merged store word (MERGE→WRITE, unconditional).
- WRITE: the unit issues the write. On `mem_ready`, WRITE→IDLE.

A one-cycle `done` pulse marks the end of each operation.

Top module: `partial_word_merge`

## Requirements
- R1: The byte offset is `req_addr[1:0]`. Every memory beat uses `req_addr` with those two bits cleared. While `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold steady.
- R2: Operation codes are `req_op` = 00 left load, 01 right load, 10 left store, 11 right store. `req_big_endian`=1 selects big-endian. A big-endian left load at offset k gives `(M << 8k) | (R & low_mask(8k))`, where M is the memory word and R is the register value.
- R3: A little-endian left load at offset k gives the big-endian left-load result for offset 3-k. So offset 3 returns M unchanged.
- R4: A big-endian right load at offset k keeps R above bit 8(k+1) and fills the low k+1 bytes with `M >> 8(3-k)`. So offset 3 returns M.
- R5: A little-endian right load at offset 0 returns R unchanged. At offsets 1, 2 and 3 it fills the low 24, 16 and 8 bits of R with `M >> 8`, `M >> 16` and `M >> 24`.
- R6: A big-endian left store at offset k writes `(M & ~(0xFFFFFFFF >> 8k)) | (R >> 8k)`. So offset 0 writes R.
- R7: A big-endian right store at offset k writes `(R << 8(3-k)) | (M & low_mask(8(3-k)))`. So offset 3 writes R.
- R8: A little-endian store at offset k writes the word that the big-endian store of the same direction writes at offset 3-k.
- R9: A store makes exactly one read and then exactly one write of the merged word, at the same aligned address. A load never writes memory.
- R10: Latency is counted from the rising edge that accepts the request, plus one cycle for every cycle the memory holds `mem_ready` low. For a load, `done` rises 1 edge later. For a store, it rises 3 edges later.
- R11: `done` is high for exactly one cycle. `req_ready` is low from the accepting edge until the operation finishes.
- R12: After reset, `req_ready`=1, `done`=0, `mem_req`=0 and `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; request accepted when both high |
| req_op | input | 2 | bit1 = store, bit0 = right |
| req_addr | input | ADDR_W (16) | Byte address |
| req_big_endian | input | 1 | 1 = big-endian lane mapping |
| req_reg_data | input | DATA_W (32) | Current register value |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W (32) | Merged register value (load) or written word (store) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | ADDR_W (16) | Aligned word address |
| mem_wdata | output | DATA_W (32) | Merged store word |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_rdata | input | DATA_W (32) | Read word, valid with `mem_ready` |

## Verification
Requests are driven on a falling edge. Results are sampled on later falling edges, counted from the edge that accepts the request.

A load's `result` and `done` are due at the second falling edge, and a store's at the fourth. Every cycle the bench holds `mem_ready` low pushes this one edge later. The bench checks the exact falling edge at which `done` first appears against that count. It reads `result` and the memory contents only at that edge.

The next falling edge confirms that `done` has dropped. The falling edge right after acceptance confirms that `req_ready` is low.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        OP_LD_LEFT  = 2'b00,
        OP_LD_RIGHT = 2'b01,
        OP_ST_LEFT  = 2'b10,
        OP_ST_RIGHT = 2'b11
    } merge_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_MERGE,
        ST_WRITE
    } merge_state_e;

endpackage

// File: rtl/pwm_load_merge.sv
module pwm_load_merge #(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  off,
    input  logic              big_endian,
    input  logic              right,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] reg_word,
    output logic [DATA_W-1:0] merged
);

    logic [OFF_W-1:0]  eff;
    logic [DATA_W-1:0] shifted;
    logic [LANES-1:0]  take_mem;
    logic              keep_all;

    // Little-endian lane positions are the big-endian ones mirrored.
    assign eff      = big_endian ? off : (OFF_W'(LANES - 1) - off);
    assign keep_all = right && !big_endian && (off == '0);
    assign shifted  = right ? (mem_word >> (8 * (LANES - 1 - int'(eff))))
                            : (mem_word << (8 * int'(eff)));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (right) take_mem[i] = (i <= int'(eff)) && !keep_all;
            else       take_mem[i] = (i >= int'(eff));
        end
        assign merged[8*i +: 8] = take_mem[i] ? shifted[8*i +: 8] : reg_word[8*i +: 8];
    end

    always_comb begin
        if (right && !big_endian && off == '0) begin
            // R5
            le_right_zero_chk: assert (merged == reg_word);
        end
    end

endmodule

// File: rtl/pwm_store_merge.sv
module pwm_store_merge #(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [OFF_W-1:0]  off,
    input  logic              big_endian,
    input  logic              right,
    input  logic [DATA_W-1:0] mem_word,
    input  logic [DATA_W-1:0] reg_word,
    output logic [DATA_W-1:0] merged
);

    logic [OFF_W-1:0]  eff;
    logic [DATA_W-1:0] shifted;
    logic [LANES-1:0]  take_reg;

    assign eff     = big_endian ? off : (OFF_W'(LANES - 1) - off);
    assign shifted = right ? (reg_word << (8 * (LANES - 1 - int'(eff))))
                           : (reg_word >> (8 * int'(eff)));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (right) take_reg[i] = (i >= LANES - 1 - int'(eff));
            else       take_reg[i] = (i <= LANES - 1 - int'(eff));
        end
        assign merged[8*i +: 8] = take_reg[i] ? shifted[8*i +: 8] : mem_word[8*i +: 8];
    end

    always_comb begin
        if (big_endian && !right && off == '0) begin
            // R6
            be_left_whole_chk: assert (merged == reg_word);
        end
    end

endmodule

// File: rtl/partial_word_merge.sv
module partial_word_merge
    import pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_big_endian,
    input  logic [DATA_W-1:0] req_reg_data,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    merge_state_e      state_q, state_d;
    merge_op_e         op_q;
    logic [ADDR_W-1:0] addr_q;
    logic              be_q;
    logic [DATA_W-1:0] reg_q;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] merged_q;
    logic [DATA_W-1:0] result_q;
    logic              done_q;
    logic [DATA_W-1:0] load_out;
    logic [DATA_W-1:0] store_out;
    logic              is_store;

    assign is_store = op_q[1];

    pwm_load_merge #(.DATA_W(DATA_W)) u_load (
        .off        (addr_q[OFF_W-1:0]),
        .big_endian (be_q),
        .right      (op_q[0]),
        .mem_word   (mem_rdata),
        .reg_word   (reg_q),
        .merged     (load_out)
    );

    pwm_store_merge #(.DATA_W(DATA_W)) u_store (
        .off        (addr_q[OFF_W-1:0]),
        .big_endian (be_q),
        .right      (op_q[0]),
        .mem_word   (word_q),
        .reg_word   (reg_q),
        .merged     (store_out)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_READ;
            ST_READ:  if (mem_ready) state_d = is_store ? ST_MERGE : ST_IDLE;
            ST_MERGE: state_d = ST_WRITE;
            ST_WRITE: if (mem_ready) state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_READ:  mem_req   = 1'b1;
            ST_MERGE: ;
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
        endcase
    end

    assign mem_addr  = {addr_q[ADDR_W-1:OFF_W], OFF_W'(0)};
    assign mem_wdata = merged_q;
    assign done      = done_q;
    assign result    = result_q;

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_LD_LEFT;
            addr_q   <= '0;
            be_q     <= 1'b0;
            reg_q    <= '0;
            word_q   <= '0;
            merged_q <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    op_q   <= merge_op_e'(req_op);
                    addr_q <= req_addr;
                    be_q   <= req_big_endian;
                    reg_q  <= req_reg_data;
                end
                ST_READ: if (mem_ready) begin
                    if (is_store) begin
                        word_q <= mem_rdata;
                    end else begin
                        result_q <= load_out;
                        done_q   <= 1'b1;
                    end
                end
                ST_MERGE: merged_q <= store_out;
                ST_WRITE: if (mem_ready) begin
                    result_q <= merged_q;
                    done_q   <= 1'b1;
                end
            endcase
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFF_W-1:0] == '0));

    // R1
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R9
    write_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req && mem_we) |-> $past(!mem_req));

    // R10
    load_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we && !is_store) |=> done);

endmodule

// File: tb/tb_partial_word_merge.sv
`timescale 1ns/1ps
module tb_partial_word_merge;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'b00;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_big_endian = 1'b0;
    logic [DATA_W-1:0] req_reg_data = '0;
    logic              done;
    logic [DATA_W-1:0] result;
    logic              mem_req;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ready;
    logic [DATA_W-1:0] mem_rdata;

    logic              mem_hold = 1'b0;
    logic [DATA_W-1:0] mem [16];
    logic [ADDR_W-1:0] last_waddr = '0;
    int                wcount = 0;
    int                checks = 0;
    int                fails = 0;

    always #2 clk = ~clk;

    partial_word_merge #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr,
        .req_big_endian, .req_reg_data, .done, .result, .mem_req, .mem_we,
        .mem_addr, .mem_wdata, .mem_ready, .mem_rdata
    );

    assign mem_ready = mem_req && !mem_hold;
    assign mem_rdata = mem[mem_addr[5:2]];

    always @(posedge clk) begin
        if (mem_req && mem_ready && mem_we) begin
            mem[mem_addr[5:2]] <= mem_wdata;
            last_waddr         <= mem_addr;
            wcount             <= wcount + 1;
        end
    end

    // stimulus patterns: {register value, memory word}
    localparam logic [63:0] PATS [4] = '{
        {32'h11223344, 32'hAABBCCDD},
        {32'hFFFFFFFF, 32'h00000000},
        {32'h00000000, 32'hFFFFFFFF},
        {32'h89ABCDEF, 32'h76543210}
    };

    function automatic logic [31:0] low_mask(input int n);
        if (n <= 0) return 32'h0;
        if (n >= 32) return 32'hFFFFFFFF;
        return (32'h1 << n) - 32'h1;
    endfunction

    function automatic logic [31:0] expect_word(input logic [1:0] op, input int off,
                                                input logic be, input logic [31:0] r,
                                                input logic [31:0] m);
        int j;
        j = be ? off : 3 - off;
        case (op)
            2'b00: return (m << (8*j)) | (r & low_mask(8*j));
            2'b01: begin
                if (!be && off == 0) return r;
                return (r & ~low_mask(8*(j+1))) | (m >> (8*(3-j)));
            end
            2'b10: return (m & ~(32'hFFFFFFFF >> (8*j))) | (r >> (8*j));
            default: return (r << (8*(3-j))) | (m & low_mask(8*(3-j)));
        endcase
    endfunction

    function automatic string req_tag(input logic [1:0] op, input logic be);
        if (op[1] && !be) return "R8";
        case (op)
            2'b00: return be ? "R2" : "R3";
            2'b01: return be ? "R4" : "R5";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input int off, input logic be,
                          input logic [31:0] r, input logic [31:0] m,
                          input int idx, input int stalls);
        logic [31:0]       exp;
        logic [ADDR_W-1:0] aligned;
        int                k;
        int                wc0;
        string             tag;
        exp     = expect_word(op, off, be, r, m);
        tag     = req_tag(op, be);
        aligned = ADDR_W'(16'h0100 | (idx << 2));
        @(negedge clk);
        mem[idx]       <= m;
        wc0            = wcount;
        req_valid      = 1'b1;
        req_op         = op;
        req_addr       = aligned | ADDR_W'(off);
        req_big_endian = be;
        req_reg_data   = r;
        if (stalls > 0) mem_hold = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        check("R11 ready low while busy", {31'h0, req_ready}, 32'h0);
        while (!done && k < 64) begin
            if (k == stalls + 1) mem_hold = 1'b0;
            @(negedge clk);
            k++;
        end
        mem_hold = 1'b0;
        // R10: done due at edge count 2 (load) or 4 (store) plus stalls
        check("R10 latency", 32'(k), 32'((op[1] ? 4 : 2) + stalls));
        check(tag, result, exp);
        if (op[1]) begin
            check("R9 memory word", mem[idx], exp);
            check("R9 one write", 32'(wcount - wc0), 32'h1);
            check("R1 write address", 32'(last_waddr), 32'(aligned));
        end else begin
            check("R9 load leaves memory", mem[idx], m);
            check("R9 load no write", 32'(wcount - wc0), 32'h0);
        end
        @(negedge clk);
        check("R11 done single cycle", {31'h0, done}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 req_ready", {31'h0, req_ready}, 32'h1);
        check("R12 done", {31'h0, done}, 32'h0);
        check("R12 mem_req", {31'h0, mem_req}, 32'h0);
        check("R12 result", result, 32'h0);
        rst_n = 1'b1;

        for (int p = 0; p < 4; p++)
            for (int op = 0; op < 4; op++)
                for (int be = 0; be < 2; be++)
                    for (int off = 0; off < 4; off++)
                        run_op(2'(op), off, 1'(be), PATS[p][63:32], PATS[p][31:0],
                               (p * 4 + op * 2 + be) % 16, 0);

        // R10 stalled memory: store held 3 cycles, load held 2 cycles
        run_op(2'b11, 1, 1'b0, 32'hCAFEF00D, 32'h12345678, 5, 3);
        run_op(2'b01, 2, 1'b1, 32'h0BADBEEF, 32'hFEDCBA98, 6, 2);
        // R5 little-endian right load at offset 0 keeps register
        run_op(2'b01, 0, 1'b0, 32'h5A5A5A5A, 32'hA5A5A5A5, 7, 0);
        // R7 big-endian right store at offset 3 writes the whole register
        run_op(2'b11, 3, 1'b1, 32'h13579BDF, 32'h2468ACE0, 8, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule